// File: doc/BRIEF.md
# Parallel ATA PIO Host Cycle Sequencer

This block is the host end of one programmed-I/O access on a parallel ATA bus. A client presents a request with a chip-select pattern, a 3-bit register address, a read/write flag, a write word and a transfer mode number. The block accepts it when idle and runs the whole bus cycle. It asserts the selected chip-select lines and the address, waits out the address setup time, then pulls the read or write strobe low. It checks the device's ready line a fixed time into the strobe and stretches the strobe while the device holds that line low. After the strobe it holds the address, chip selects and write data, and pads the idle time so the full cycle meets the mode's minimum length. At the end it pulses `done` and presents the captured read word.

All timing comes from per-mode nanosecond figures. These are turned into whole clock cycles by ceiling division by `CLK_PERIOD_NS`. The shared data bus is modelled as separate output, input and output-enable signals. The DMA acknowledge line is held negated, because this block only performs register-style transfers.

Top module: `ata_pio_host`

## Requirements
- R1: While reset is held and right after it, both chip selects are high (`ataCsN` = 2'b11), both strobes are high, `ataDdOe` is 0, `busy` is 0, `done` is 0 and `timeout` is 0.
- R2: Chip selects and address go active a number of cycles before the strobe asserts. That number is ceil(max(address setup, write data setup)/T), where T = `CLK_PERIOD_NS` and the setups in ns for modes 0..4 are address 70, 50, 30, 30, 25 and data 60, 45, 30, 30, 20. A request bit `reqCs[i]` = 1 drives `ataCsN[i]` low. `ataDa` equals `reqAddr` whenever any chip select is low.
- R3: When IORDY is not sampled low, the strobe stays low for ceil(t/T) cycles, with t = 165, 125, 100, 80, 70 ns for modes 0..4.
- R4: `busy` is high for exactly setup + strobe + recovery cycles. Recovery is the larger of the two hold counts (R5) and ceil(cycle/T) − setup − strobe, with the cycle minimum 600, 383, 240, 180, 120 ns for modes 0..4. `done` pulses for one cycle right after `busy` falls.
- R5: After the strobe rises, chip selects and address stay valid for ceil(h/T) cycles, with h = 20, 15, 10, 10, 10 ns. Write data stays enabled for ceil(d/T) cycles, with d = 30, 20, 15, 10, 10 ns. Both stay unchanged while the strobe is low.
- R6: On a write, `ataDdOe` is high from the first chip-select cycle through the data hold, with `ataDdOut` = `reqWdata`. On a read, `ataDdOe` is never high.
- R7: IORDY is sampled at the clock edge that ends strobe cycle S = ceil(35/T). If it is low there, the strobe count freezes until IORDY is seen high, and then the remaining strobe cycles follow. Read data is captured from `ataDdIn` at the last strobe-low edge, so a device that holds IORDY low for W ≥ S sampled edges gives a strobe of (R3 width) + W − S + 1 cycles.
- R8: If IORDY is still low after ceil(1250/T) waiting cycles, the strobe is released, the normal recovery follows, and `done` is accompanied by `timeout` = 1. Otherwise `timeout` = 0 with `done`.
- R9: A request held while `busy` is high is ignored. The running cycle keeps the mode, address and data it started with, and no second cycle starts after `done`.
- R10: Mode values 5, 6 and 7 run with mode 4 timing.
- R11: `ataDmackN` stays high at all times.
- R12: Only `ataDiorN` goes low for reads and only `ataDiowN` for writes. Both are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period `CLK_PERIOD_NS` |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when `busy` is 0 |
| reqCs | input | 2 | Chip selects to activate (1 = assert), must be nonzero |
| reqAddr | input | 3 | Device register address |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqWdata | input | 16 | Word to write |
| reqMode | input | 3 | PIO timing mode, 5..7 treated as 4 |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Valid with `done`: the cycle was aborted on IORDY |
| rdata | output | 16 | Word captured on the last read |
| ataCsN | output | 2 | Active-low chip selects |
| ataDa | output | 3 | Device address lines |
| ataDiorN | output | 1 | Active-low read strobe |
| ataDiowN | output | 1 | Active-low write strobe |
| ataDmackN | output | 1 | DMA acknowledge, held negated |
| ataDdOut | output | 16 | Data bus drive value |
| ataDdOe | output | 1 | Data bus drive enable |
| ataDdIn | input | 16 | Data bus receive value |
| ataIordy | input | 1 | Device ready, low inserts wait states |

## Verification
Some properties are checked on every cycle: the two strobes never overlap, a read never drives the bus, chip selects cover every strobe-low cycle and appear before it, the address stays still while the strobe is low, the wait counter stays under its limit and the latched timing holds steady while busy. The exact cycle counts cannot be seen by those local checks, so the bench scenarios show them. These are the setup, strobe, hold and recovery counts for every mode, the stretch length for a given IORDY pattern, the exact abort boundary, the read word taken at the strobe's end, and requests ignored while busy.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_WAIT,
    PH_RECOV
  } pioPhase_t;

  // strobes from the sequencer to the pin datapath
  typedef struct packed {
    logic load;      // request accepted this cycle
    logic csOn;      // chip selects and address valid
    logic strobeOn;  // read or write strobe low
    logic dataOn;    // write data may drive the bus
    logic capture;   // last strobe-low edge of a completed strobe
    logic finish;    // last recovery cycle
    logic timedOut;  // current cycle was aborted on IORDY
  } pioCtl_t;

  function automatic int ceilDiv(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int clampMode(input int m);
    return (m > 4) ? 4 : m;
  endfunction

  function automatic int cycleNs(input int m);
    case (clampMode(m))
      0: return 600;
      1: return 383;
      2: return 240;
      3: return 180;
      default: return 120;
    endcase
  endfunction

  function automatic int addrSetupNs(input int m);
    case (clampMode(m))
      0: return 70;
      1: return 50;
      2: return 30;
      3: return 30;
      default: return 25;
    endcase
  endfunction

  function automatic int activeNs(input int m);
    case (clampMode(m))
      0: return 165;
      1: return 125;
      2: return 100;
      3: return 80;
      default: return 70;
    endcase
  endfunction

  function automatic int addrHoldNs(input int m);
    case (clampMode(m))
      0: return 20;
      1: return 15;
      default: return 10;
    endcase
  endfunction

  function automatic int dataSetupNs(input int m);
    case (clampMode(m))
      0: return 60;
      1: return 45;
      2: return 30;
      3: return 30;
      default: return 20;
    endcase
  endfunction

  function automatic int dataHoldNs(input int m);
    case (clampMode(m))
      0: return 30;
      1: return 20;
      2: return 15;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/ata_pio_ctrl.sv
module ata_pio_ctrl
  import ata_pio_pkg::*;
#(
  parameter int CLK_PERIOD_NS    = 5,
  parameter int MODE_W           = 3,
  parameter int IORDY_SAMPLE_NS  = 35,
  parameter int IORDY_TIMEOUT_NS = 1250
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MODE_W-1:0] reqMode,
  input  logic              iordy,
  output logic              busy,
  output pioCtl_t           ctl
);

  localparam int NUM_SEL    = 2 ** MODE_W;
  localparam int SAMPLE_CYC = maxInt(ceilDiv(IORDY_SAMPLE_NS, CLK_PERIOD_NS), 1);
  localparam int TO_CYC     = maxInt(ceilDiv(IORDY_TIMEOUT_NS, CLK_PERIOD_NS), 1);
  localparam int CNT_MAX    = ceilDiv(cycleNs(0) + activeNs(0) + addrSetupNs(0), CLK_PERIOD_NS)
                              + SAMPLE_CYC + 2;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int TO_W       = $clog2(TO_CYC + 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYC - 1);
  localparam logic [TO_W-1:0]  TO_LAST     = TO_W'(TO_CYC - 1);

  // per-mode cycle counts, one entry per mode code
  logic [CNT_W-1:0] tabSetup  [NUM_SEL];
  logic [CNT_W-1:0] tabActive [NUM_SEL];
  logic [CNT_W-1:0] tabRecov  [NUM_SEL];
  logic [CNT_W-1:0] tabAHold  [NUM_SEL];
  logic [CNT_W-1:0] tabDHold  [NUM_SEL];

  for (genvar m = 0; m < NUM_SEL; m++) begin : g_modeTab
    localparam int SETUP_C  = maxInt(ceilDiv(addrSetupNs(m), CLK_PERIOD_NS),
                                     ceilDiv(dataSetupNs(m), CLK_PERIOD_NS));
    localparam int ACTIVE_C = maxInt(ceilDiv(activeNs(m), CLK_PERIOD_NS), SAMPLE_CYC + 1);
    localparam int AHOLD_C  = maxInt(ceilDiv(addrHoldNs(m), CLK_PERIOD_NS), 1);
    localparam int DHOLD_C  = maxInt(ceilDiv(dataHoldNs(m), CLK_PERIOD_NS), 1);
    localparam int RECOV_C  = maxInt(maxInt(AHOLD_C, DHOLD_C),
                                     ceilDiv(cycleNs(m), CLK_PERIOD_NS) - SETUP_C - ACTIVE_C);
    assign tabSetup[m]  = CNT_W'(SETUP_C);
    assign tabActive[m] = CNT_W'(ACTIVE_C);
    assign tabRecov[m]  = CNT_W'(RECOV_C);
    assign tabAHold[m]  = CNT_W'(AHOLD_C);
    assign tabDHold[m]  = CNT_W'(DHOLD_C);
  end

  pioPhase_t        phase;
  logic [CNT_W-1:0] cnt;
  logic [TO_W-1:0]  waitCnt;
  logic             timedOut;
  logic [CNT_W-1:0] setupCyc, activeCyc, recovCyc, aHoldCyc, dHoldCyc;

  logic sampleLow, lastActive, resume, expire, strobeEnd, lastRecov;

  always_comb begin
    sampleLow  = (phase == PH_ACTIVE) && (cnt == SAMPLE_LAST) && !iordy;
    lastActive = (cnt + 1'b1 == activeCyc);
    resume     = (phase == PH_WAIT) && iordy;
    expire     = (phase == PH_WAIT) && !iordy && (waitCnt == TO_LAST);
    strobeEnd  = ((phase == PH_ACTIVE) && !sampleLow && lastActive) ||
                 (resume && lastActive) || expire;
    lastRecov  = (phase == PH_RECOV) && (cnt + 1'b1 == recovCyc);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      waitCnt   <= '0;
      timedOut  <= 1'b0;
      setupCyc  <= '0;
      activeCyc <= '0;
      recovCyc  <= '0;
      aHoldCyc  <= '0;
      dHoldCyc  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            phase     <= PH_SETUP;
            cnt       <= '0;
            timedOut  <= 1'b0;
            setupCyc  <= tabSetup[reqMode];
            activeCyc <= tabActive[reqMode];
            recovCyc  <= tabRecov[reqMode];
            aHoldCyc  <= tabAHold[reqMode];
            dHoldCyc  <= tabDHold[reqMode];
          end
        end
        PH_SETUP: begin
          if (cnt + 1'b1 == setupCyc) begin
            phase <= PH_ACTIVE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ACTIVE: begin
          if (sampleLow) begin
            phase   <= PH_WAIT;
            waitCnt <= '0;
          end else if (strobeEnd) begin
            phase <= PH_RECOV;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_WAIT: begin
          if (strobeEnd) begin
            phase    <= PH_RECOV;
            cnt      <= '0;
            timedOut <= expire;
          end else if (resume) begin
            phase <= PH_ACTIVE;
            cnt   <= cnt + 1'b1;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        PH_RECOV: begin
          if (lastRecov) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    busy         = (phase != PH_IDLE);
    ctl.load     = (phase == PH_IDLE) && reqValid;
    ctl.strobeOn = (phase == PH_ACTIVE) || (phase == PH_WAIT);
    ctl.csOn     = (phase == PH_SETUP) || ctl.strobeOn ||
                   ((phase == PH_RECOV) && (cnt < aHoldCyc));
    ctl.dataOn   = (phase == PH_SETUP) || ctl.strobeOn ||
                   ((phase == PH_RECOV) && (cnt < dHoldCyc));
    ctl.capture  = strobeEnd && !expire;
    ctl.finish   = lastRecov;
    ctl.timedOut = timedOut;
  end

  // R8: the wait counter never passes the abort limit
  assert_wait_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAIT) |-> (waitCnt < TO_W'(TO_CYC)));

  // R9: timing taken at the start stays put for the whole cycle
  assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(activeCyc) && $stable(recovCyc) && $stable(setupCyc)));

endmodule

// File: rtl/ata_pio_datapath.sv
module ata_pio_datapath
  import ata_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int CS_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pioCtl_t           ctl,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ataDdIn,
  output logic [CS_W-1:0]   ataCsN,
  output logic [ADDR_W-1:0] ataDa,
  output logic              ataDiorN,
  output logic              ataDiowN,
  output logic              ataDmackN,
  output logic [DATA_W-1:0] ataDdOut,
  output logic              ataDdOe,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              timeout
);

  logic [CS_W-1:0]   csReg;
  logic [ADDR_W-1:0] addrReg;
  logic              writeReg;
  logic [DATA_W-1:0] wdataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csReg    <= '0;
      addrReg  <= '0;
      writeReg <= 1'b0;
      wdataReg <= '0;
      rdata    <= '0;
      done     <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      if (ctl.load) begin
        csReg    <= reqCs;
        addrReg  <= reqAddr;
        writeReg <= reqWrite;
        wdataReg <= reqWdata;
      end
      if (ctl.capture && !writeReg) rdata <= ataDdIn;
      done    <= ctl.finish;
      timeout <= ctl.finish && ctl.timedOut;
    end
  end

  always_comb begin
    ataCsN    = ctl.csOn ? ~csReg : '1;
    ataDa     = ctl.csOn ? addrReg : '0;
    ataDiorN  = !(ctl.strobeOn && !writeReg);
    ataDiowN  = !(ctl.strobeOn && writeReg);
    ataDmackN = 1'b1;
    ataDdOut  = wdataReg;
    ataDdOe   = ctl.dataOn && writeReg;
  end

  logic strobeAny;
  assign strobeAny = !ataDiorN || !ataDiowN;

  // R12: read and write strobes never overlap
  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(!ataDiorN && !ataDiowN));

  // R5: a chip select is active on every strobe-low cycle
  assert_cs_covers_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobeAny |-> (ataCsN != '1));

  // R5: address and selects do not move under a low strobe
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobeAny && $past(strobeAny)) |-> ($stable(ataDa) && $stable(ataCsN)));

  // R2: selects were already active the cycle before the strobe fell
  assert_setup_before_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeAny) |-> ($past(ataCsN) != '1));

  // R6: the bus is never driven while the read strobe is low
  assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ataDiorN |-> !ataDdOe);

endmodule

// File: rtl/ata_pio_host.sv
module ata_pio_host
  import ata_pio_pkg::*;
#(
  parameter int CLK_PERIOD_NS    = 5,
  parameter int DATA_W           = 16,
  parameter int ADDR_W           = 3,
  parameter int CS_W             = 2,
  parameter int MODE_W           = 3,
  parameter int IORDY_SAMPLE_NS  = 35,
  parameter int IORDY_TIMEOUT_NS = 1250
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [MODE_W-1:0] reqMode,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic [DATA_W-1:0] rdata,
  output logic [CS_W-1:0]   ataCsN,
  output logic [ADDR_W-1:0] ataDa,
  output logic              ataDiorN,
  output logic              ataDiowN,
  output logic              ataDmackN,
  output logic [DATA_W-1:0] ataDdOut,
  output logic              ataDdOe,
  input  logic [DATA_W-1:0] ataDdIn,
  input  logic              ataIordy
);

  pioCtl_t ctl;

  ata_pio_ctrl #(
    .CLK_PERIOD_NS   (CLK_PERIOD_NS),
    .MODE_W          (MODE_W),
    .IORDY_SAMPLE_NS (IORDY_SAMPLE_NS),
    .IORDY_TIMEOUT_NS(IORDY_TIMEOUT_NS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqMode (reqMode),
    .iordy   (ataIordy),
    .busy    (busy),
    .ctl     (ctl)
  );

  ata_pio_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .CS_W  (CS_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqCs    (reqCs),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .ataDdIn  (ataDdIn),
    .ataCsN   (ataCsN),
    .ataDa    (ataDa),
    .ataDiorN (ataDiorN),
    .ataDiowN (ataDiowN),
    .ataDmackN(ataDmackN),
    .ataDdOut (ataDdOut),
    .ataDdOe  (ataDdOe),
    .rdata    (rdata),
    .done     (done),
    .timeout  (timeout)
  );

endmodule

// File: tb/ata_pio_host_bench.sv
`timescale 1ns/1ps
module ata_pio_host_bench;

  localparam int PER      = 5;
  localparam int SAMPLE_C = (35 + PER - 1) / PER;
  localparam int TO_C     = (1250 + PER - 1) / PER;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqCs = 2'b01;
  logic [2:0]  reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqWdata = '0;
  logic [2:0]  reqMode = '0;
  logic        busy, done, timeout;
  logic [15:0] rdata;
  logic [1:0]  ataCsN;
  logic [2:0]  ataDa;
  logic        ataDiorN, ataDiowN, ataDmackN, ataDdOe;
  logic [15:0] ataDdOut;
  logic [15:0] ataDdIn = '0;
  logic        ataIordy = 1'b1;

  always #2.5 clk = ~clk;

  ata_pio_host u_ata_pio_host (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCs(reqCs), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .reqMode(reqMode), .busy(busy),
    .done(done), .timeout(timeout), .rdata(rdata), .ataCsN(ataCsN), .ataDa(ataDa),
    .ataDiorN(ataDiorN), .ataDiowN(ataDiowN), .ataDmackN(ataDmackN),
    .ataDdOut(ataDdOut), .ataDdOe(ataDdOe), .ataDdIn(ataDdIn), .ataIordy(ataIordy)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit hung    = 1'b0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) hung <= 1'b1;
  end

  // expectations for the transfer in flight
  logic [1:0]  expCs;
  logic [2:0]  expAddr;
  logic        expWrite;
  logic [15:0] expWdata;
  logic [15:0] devData;
  int          waitN;

  // monitor counters
  int busyCnt, setupCnt, strobeCnt, holdCnt, dHoldCnt, oeSetup, lowCnt;
  int addrErr, dataErr, oeErr, wrongStrobe, dmackErr;
  bit seenStrobe;

  task automatic clearMon();
    busyCnt = 0; setupCnt = 0; strobeCnt = 0; holdCnt = 0; dHoldCnt = 0;
    oeSetup = 0; lowCnt = 0; addrErr = 0; dataErr = 0; oeErr = 0;
    wrongStrobe = 0; seenStrobe = 1'b0;
  endtask

  // device model and bus monitor, all on the falling edge
  always @(negedge clk) begin
    bit strobeLow, csAct;
    strobeLow = !ataDiorN || !ataDiowN;
    csAct     = (ataCsN != 2'b11);
    if (!ataDmackN) dmackErr++;
    if (rstN) begin
      if (busy) busyCnt++;
      if (strobeLow) begin
        strobeCnt++;
        seenStrobe = 1'b1;
        lowCnt++;
        if (expWrite ? !ataDiorN : !ataDiowN) wrongStrobe++;
      end else if (seenStrobe) begin
        if (csAct) holdCnt++;
        if (ataDdOe) dHoldCnt++;
      end else begin
        if (csAct) setupCnt++;
        if (ataDdOe) oeSetup++;
      end
      if (csAct && (ataDa != expAddr || ataCsN != ~expCs)) addrErr++;
      if (ataDdOe && ataDdOut != expWdata) dataErr++;
      if (!expWrite && ataDdOe) oeErr++;
    end
    ataIordy <= !(strobeLow && lowCnt <= waitN);
    ataDdIn  <= (strobeLow && lowCnt >= waitN) ? devData : ~devData;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cdiv(input int ns);
    return (ns + PER - 1) / PER;
  endfunction

  function automatic int eff(input int m);
    return (m > 4) ? 4 : m;
  endfunction

  function automatic int expSetup(input int m);
    int a[5] = '{70, 50, 30, 30, 25};
    int d[5] = '{60, 45, 30, 30, 20};
    return (cdiv(a[eff(m)]) > cdiv(d[eff(m)])) ? cdiv(a[eff(m)]) : cdiv(d[eff(m)]);
  endfunction

  function automatic int expActive(input int m);
    int t[5] = '{165, 125, 100, 80, 70};
    return cdiv(t[eff(m)]);
  endfunction

  function automatic int expAHold(input int m);
    int t[5] = '{20, 15, 10, 10, 10};
    return cdiv(t[eff(m)]);
  endfunction

  function automatic int expDHold(input int m);
    int t[5] = '{30, 20, 15, 10, 10};
    return cdiv(t[eff(m)]);
  endfunction

  function automatic int expRecov(input int m);
    int t[5] = '{600, 383, 240, 180, 120};
    int r, h;
    r = cdiv(t[eff(m)]) - expSetup(m) - expActive(m);
    h = (expAHold(m) > expDHold(m)) ? expAHold(m) : expDHold(m);
    return (r > h) ? r : h;
  endfunction

  task automatic runCycle(input int mode, input bit wr, input logic [1:0] cs,
                          input logic [2:0] addr, input logic [15:0] wd,
                          input logic [15:0] dd, input int wN, input bit blockTest);
    int eStrobe, eBusy;
    bit eTo;
    string rm;
    @(negedge clk);
    clearMon();
    expCs = cs; expAddr = addr; expWrite = wr; expWdata = wd; devData = dd; waitN = wN;
    reqCs = cs; reqAddr = addr; reqWrite = wr; reqWdata = wd; reqMode = 3'(mode);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (blockTest) begin
      // R9: a competing request while busy must not disturb the cycle
      reqValid = 1'b1; reqMode = 3'd4; reqAddr = ~addr; reqCs = ~cs;
      reqWdata = ~wd; reqWrite = ~wr;
      repeat (10) @(negedge clk);
      reqValid = 1'b0;
    end
    while (!done && !hung) @(negedge clk);

    eTo = (wN >= SAMPLE_C + TO_C);
    if (eTo) eStrobe = SAMPLE_C + TO_C;
    else if (wN >= SAMPLE_C) eStrobe = expActive(mode) + wN - SAMPLE_C + 1;
    else eStrobe = expActive(mode);
    eBusy = expSetup(mode) + eStrobe + expRecov(mode);
    rm = (mode > 4) ? "R10" : "R3";

    chk(setupCnt == expSetup(mode), "R2", "setup cycles", setupCnt, expSetup(mode));
    chk(addrErr == 0, "R2", "address/select mismatches", addrErr, 0);
    chk(strobeCnt == eStrobe, (wN >= SAMPLE_C) ? "R7" : rm, "strobe cycles", strobeCnt, eStrobe);
    chk(busyCnt == eBusy, "R4", "busy cycles", busyCnt, eBusy);
    chk(holdCnt == expAHold(mode), "R5", "select hold cycles", holdCnt, expAHold(mode));
    chk(timeout == eTo, "R8", "timeout flag", int'(timeout), int'(eTo));
    chk(wrongStrobe == 0, "R12", "wrong strobe cycles", wrongStrobe, 0);
    if (wr) begin
      chk(oeSetup == expSetup(mode), "R6", "write drive before strobe", oeSetup, expSetup(mode));
      chk(dHoldCnt == expDHold(mode), "R5", "write data hold cycles", dHoldCnt, expDHold(mode));
      chk(dataErr == 0, "R6", "write data mismatches", dataErr, 0);
    end else begin
      chk(oeErr == 0, "R6", "read drove the bus", oeErr, 0);
      if (!eTo) chk(rdata == dd, "R7", "read data", int'(rdata), int'(dd));
    end
    if (blockTest) begin
      chk(busy == 1'b0, "R9", "busy at done", int'(busy), 0);
      @(negedge clk);
      chk(busy == 1'b0, "R9", "no stale cycle after done", int'(busy), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h1DE5_0A7A));
    dmackErr = 0;
    expWrite = 1'b0; expCs = 2'b01; expAddr = '0; expWdata = '0; devData = '0; waitN = 0;
    clearMon();
    repeat (3) @(negedge clk);
    // R1: idle pins under reset
    chk(ataCsN == 2'b11 && ataDiorN && ataDiowN && !ataDdOe, "R1", "bus idle in reset",
        int'({ataCsN, ataDiorN, ataDiowN, ataDdOe}), 5'b11110);
    chk(!busy && !done && !timeout, "R1", "status in reset", int'({busy, done, timeout}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(ataCsN == 2'b11 && ataDiorN && ataDiowN && !ataDdOe && !busy && !done, "R1",
        "idle after reset", int'({ataCsN, ataDiorN, ataDiowN, ataDdOe, busy, done}), 7'b1111000);

    // directed corners
    runCycle(0, 1'b1, 2'b01, 3'd0, 16'hA55A, 16'h0000, 0, 1'b0);
    runCycle(4, 1'b0, 2'b10, 3'd6, 16'h0000, 16'h1234, 0, 1'b0);
    runCycle(2, 1'b0, 2'b01, 3'd7, 16'h0000, 16'hBEEF, SAMPLE_C - 1, 1'b0);
    runCycle(2, 1'b0, 2'b01, 3'd7, 16'h0000, 16'hC0DE, SAMPLE_C, 1'b0);
    runCycle(3, 1'b0, 2'b01, 3'd1, 16'h0000, 16'h7E57, SAMPLE_C + TO_C - 1, 1'b0);
    runCycle(1, 1'b1, 2'b10, 3'd2, 16'hF00D, 16'h0000, SAMPLE_C + TO_C, 1'b0);
    runCycle(1, 1'b0, 2'b01, 3'd3, 16'h0000, 16'h4321, SAMPLE_C + TO_C, 1'b0);
    runCycle(6, 1'b0, 2'b01, 3'd5, 16'h0000, 16'h5A5A, 0, 1'b0);  // R10
    runCycle(7, 1'b1, 2'b10, 3'd4, 16'h9696, 16'h0000, 0, 1'b0);  // R10
    runCycle(0, 1'b1, 2'b01, 3'd3, 16'h1357, 16'h0000, 0, 1'b1);  // R9
    runCycle(3, 1'b0, 2'b10, 3'd6, 16'h0000, 16'h2468, 12, 1'b1); // R9

    for (int i = 0; i < 40; i++) begin
      int w;
      w = ($urandom_range(0, 9) < 6) ? 0 : int'($urandom_range(0, 60));
      runCycle(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
               ($urandom_range(0, 1) != 0) ? 2'b01 : 2'b10, 3'($urandom_range(0, 7)),
               16'($urandom), 16'($urandom), w, 1'b0);
      if (hung) break;
    end

    chk(dmackErr == 0, "R11", "DMA acknowledge asserted cycles", dmackErr, 0);
    if (hung) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule